// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is the transmit side of an SPI master, working in clock mode 0. Software writes one byte into a single-entry holding register, along with a select code. The sequencer moves that byte into a shift register as soon as the serial engine can accept it. It then sends the byte most significant bit first, and keeps the last byte received on the input line.

Its main job is to decide what the four select outputs do between consecutive words. The outcome depends on four things:
- whether the next word reached the holding register in time;
- whether that word targets the same select;
- the keep-asserted bit of the current select;
- a one-shot final-word flag.

Each select also has a programmable gap between consecutive words.

The select outputs can drive the slave-select pins directly, one active-low line per slave. They can also carry a 4-bit code to an external 1-of-n decoder, which reaches up to fifteen slaves. Code 4'hF means that no slave is selected.

Top module: `spi_cs_seq`

## Requirements
- R1: After reset, `sel_n` is 4'hF, `spck` is 0, `mosi` is 0, `hold_empty` is 1 and `rx_data` is 0.
- R2: Writes go to address 0 (data). Bits [7:0] are the word and bits [11:8] are the select code. The write sets `hold_empty` to 0 on the next clock. `hold_empty` returns to 1 once the word moves into the shift register, which takes one further cycle when the engine is idle.
- R3: `spck` idles low, and each of its half periods lasts div+1 clocks. Bits leave MSB first. `mosi` changes only when `spck` falls, and `miso` is sampled when `spck` rises. After the eighth rising edge, the received byte appears on `rx_data`.
- R4: Suppose a word for the same select is waiting when the inter-word gap ends. The select then stays asserted with no release between the two words.
- R5: Suppose the keep bit of the current select is 0 and no same-select word is waiting. The select is then released after the gap.
- R6: Suppose the keep bit is 1. The select then stays asserted after a word for as long as no new word arrives.
- R7: Address 1 (mode) sets the final-word flag with bit [1]. A word loaded while the flag is set releases its select after its gap, even when the keep bit is 1. The flag clears at that release, so the next word on a kept select is held again.
- R8: Moving to a different select first releases the old one. All lines then stay high for at least div+1 clocks, and in direct mode no two lines are ever low together.
- R9: Address 2 (config) sets two things for the select given in bits [1:0]: the keep bit in bit [2] and the gap dly in bits [15:8]. Between two words on a held select, `spck` stays low for dly+div+2 clocks.
- R10: Mode bit [0] set to 1 selects decoded output. `sel_n` then carries the 4-bit select code while the select is active and 4'hF otherwise. Config lookups use the low two bits of the code. Mode bits [15:8] set div.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 data, 1 mode, 2 select config |
| wr_data | input | 16 | Register write data |
| hold_empty | output | 1 | Holding register can take a new word |
| spck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 4 | Select lines, direct active-low or decoded code |
| rx_data | output | 8 | Last byte received |

## Verification
Single isolated words confirm bit order, sampling edges and half-period length. They also show that a select with a clear keep bit is released exactly once per word. Back-to-back same-select pairs confirm that the select is not released between the words, and show the gap timing as the longest low stretch of the serial clock. A kept select is left idle for a long stretch, then closed with the final-word flag and reused. Together these separate hold, release and flag self-clearing. A change of select code while a line is held checks the release-before-switch ordering. Decoded mode shows the code on the outputs, and randomized dividers, gaps, codes and data cover combinations the directed cases miss.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_HOLD,
        ST_REL
    } seq_st_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_CFG  = 2'd2;
endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
    import spi_cs_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int SEL_W  = 4,
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [1:0]                      wr_addr,
    input  logic [15:0]                     wr_data,
    input  logic                            pop,
    input  logic                            clr_last,
    output logic                            hold_valid,
    output logic [WORD_W-1:0]               hold_data,
    output logic [SEL_W-1:0]                hold_sel,
    output logic [NUM_CS-1:0]               keep,
    output logic [NUM_CS-1:0][DLY_W-1:0]    dly,
    output logic [DIV_W-1:0]                div,
    output logic                            decode,
    output logic                            last
);
    localparam int IDX_W   = $clog2(NUM_CS);
    localparam int SEL_LSB = 8;
    localparam int FLD_LSB = 8;

    typedef struct packed {
        logic                         hv;
        logic [WORD_W-1:0]            hd;
        logic [SEL_W-1:0]             hs;
        logic [NUM_CS-1:0]            keep;
        logic [NUM_CS-1:0][DLY_W-1:0] dly;
        logic [DIV_W-1:0]             div;
        logic                         dec;
        logic                         last;
    } regs_t;

    regs_t q, d;
    logic [IDX_W-1:0] cfg_idx;
    logic unused_wr;

    assign cfg_idx   = wr_data[IDX_W-1:0];
    assign unused_wr = ^wr_data;

    always_comb begin
        d = q;
        if (pop)      d.hv   = 1'b0;
        if (clr_last) d.last = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADDR_DATA: begin
                    d.hv = 1'b1;
                    d.hd = wr_data[WORD_W-1:0];
                    d.hs = wr_data[SEL_LSB +: SEL_W];
                end
                ADDR_MODE: begin
                    d.dec  = wr_data[0];
                    d.last = wr_data[1];
                    d.div  = wr_data[FLD_LSB +: DIV_W];
                end
                ADDR_CFG: begin
                    d.keep[cfg_idx] = wr_data[2];
                    d.dly[cfg_idx]  = wr_data[FLD_LSB +: DLY_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold_valid = q.hv;
    assign hold_data  = q.hd;
    assign hold_sel   = q.hs;
    assign keep       = q.keep;
    assign dly        = q.dly;
    assign div        = q.div;
    assign decode     = q.dec;
    assign last       = q.last;

    // R2
    hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DATA) |=> hold_valid);
endmodule

// File: rtl/spi_cs_sel_enc.sv
module spi_cs_sel_enc #(
    parameter int SEL_W  = 4,
    parameter int NUM_CS = 4
) (
    input  logic             active,
    input  logic             decode,
    input  logic [SEL_W-1:0] code,
    output logic [SEL_W-1:0] sel_n
);
    localparam int IDX_W = $clog2(NUM_CS);

    for (genvar i = 0; i < SEL_W; i++) begin : g_line
        logic direct_n;
        assign direct_n = (code[IDX_W-1:0] != IDX_W'(i));
        assign sel_n[i] = !active ? 1'b1 : (decode ? code[i] : direct_n);
    end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    output logic              hold_empty,
    output logic              spck,
    output logic              mosi,
    input  logic              miso,
    output logic [3:0]        sel_n,
    output logic [WORD_W-1:0] rx_data
);
    localparam int SEL_W = 4;
    localparam int IDX_W = $clog2(NUM_CS);
    localparam int CNT_W = (DIV_W > DLY_W) ? DIV_W : DLY_W;
    localparam int HP_W  = $clog2(2 * WORD_W);
    localparam logic [HP_W-1:0] HP_LAST = HP_W'(2 * WORD_W - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [HP_W-1:0]   hp;
        logic [WORD_W-1:0] sh;
        logic              samp;
        logic              sck;
        logic              mosi;
        logic [SEL_W-1:0]  cur_sel;
        logic              last;
        logic [WORD_W-1:0] rx;
    } seq_t;

    seq_t q, d;
    logic pop, clr_last, load;
    logic hold_valid, decode, last_flag;
    logic [WORD_W-1:0] hold_data;
    logic [SEL_W-1:0] hold_sel;
    logic [NUM_CS-1:0] keep;
    logic [NUM_CS-1:0][DLY_W-1:0] dly;
    logic [DIV_W-1:0] div;
    logic [IDX_W-1:0] cur_idx;
    logic sel_active, unused_top;

    spi_cs_regs #(.WORD_W(WORD_W), .SEL_W(SEL_W), .NUM_CS(NUM_CS),
                  .DIV_W(DIV_W), .DLY_W(DLY_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pop(pop), .clr_last(clr_last),
        .hold_valid(hold_valid), .hold_data(hold_data), .hold_sel(hold_sel),
        .keep(keep), .dly(dly), .div(div), .decode(decode), .last(last_flag)
    );

    assign cur_idx    = q.cur_sel[IDX_W-1:0];
    assign unused_top = q.sh[WORD_W-1];

    always_comb begin
        d        = q;
        pop      = 1'b0;
        clr_last = 1'b0;
        load     = 1'b0;
        unique case (q.st)
            ST_IDLE: if (hold_valid) load = 1'b1;
            ST_SHIFT: begin
                if (q.cnt == CNT_W'(div)) begin
                    d.cnt = '0;
                    d.hp  = q.hp + 1'b1;
                    if (!q.hp[0]) begin
                        d.sck  = 1'b1;
                        d.samp = miso;
                    end else begin
                        d.sck  = 1'b0;
                        d.sh   = {q.sh[WORD_W-2:0], q.samp};
                        d.mosi = q.sh[WORD_W-2];
                        if (q.hp == HP_LAST) begin
                            d.rx = {q.sh[WORD_W-2:0], q.samp};
                            d.st = ST_GAP;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt == CNT_W'(dly[cur_idx])) begin
                    d.cnt = '0;
                    if (q.last) begin
                        d.st     = ST_REL;
                        clr_last = 1'b1;
                    end else if (hold_valid && hold_sel == q.cur_sel) begin
                        load = 1'b1;
                    end else if (keep[cur_idx]) begin
                        d.st = ST_HOLD;
                    end else begin
                        d.st = ST_REL;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (hold_valid) begin
                    if (hold_sel == q.cur_sel) begin
                        load = 1'b1;
                    end else begin
                        d.st  = ST_REL;
                        d.cnt = '0;
                    end
                end
            end
            ST_REL: begin
                if (q.cnt == CNT_W'(div)) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (load) begin
            pop       = 1'b1;
            d.st      = ST_SHIFT;
            d.sh      = hold_data;
            d.mosi    = hold_data[WORD_W-1];
            d.cur_sel = hold_sel;
            d.last    = last_flag;
            d.cnt     = '0;
            d.hp      = '0;
            d.sck     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sel_active = (q.st == ST_SHIFT) || (q.st == ST_GAP) || (q.st == ST_HOLD);

    spi_cs_sel_enc #(.SEL_W(SEL_W), .NUM_CS(NUM_CS)) i_enc (
        .active(sel_active), .decode(decode), .code(q.cur_sel), .sel_n(sel_n)
    );

    assign hold_empty = !hold_valid;
    assign spck       = q.sck;
    assign mosi       = q.mosi;
    assign rx_data    = q.rx;

    // R8
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !decode |-> $countones(~sel_n) <= 1);

    // R8
    no_direct_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != 4'hF && $past(sel_n) != 4'hF) |-> sel_n == $past(sel_n));

    // R3
    sck_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spck |-> sel_n != 4'hF);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spck && $past(spck)) |-> $stable(mosi));
endmodule

// File: tb/test_spi_cs_seq.sv
module test_spi_cs_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic hold_empty, spck, mosi, miso;
    logic [3:0] sel_n;
    logic [7:0] rx_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_cs_seq i_spi_cs_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hold_empty(hold_empty), .spck(spck), .mosi(mosi),
        .miso(miso), .sel_n(sel_n), .rx_data(rx_data)
    );

    // bench slave
    logic [7:0] slv_tx = 8'h00;
    logic [7:0] mon_rx = 8'h00;
    logic [31:0] mon_cnt = 0;
    logic [2:0] midx;
    assign midx = 3'd7 - mon_cnt[2:0];
    assign miso = slv_tx[midx];
    always @(posedge spck) begin
        mon_rx  <= {mon_rx[6:0], mosi};
        mon_cnt <= mon_cnt + 1;
    end

    // line monitors, sampled away from the active edge
    int rel_cnt = 0, sw_err = 0, two_err = 0;
    int idle_run = 0, min_idle = 1000, hi_run = 0, last_hi = 0;
    int lo_run = 0, max_lo = 0;
    bit seen_act = 0, bench_dec = 0, prev_sck = 0;
    logic [3:0] prev_sel = 4'hF;
    always @(negedge clk) if (rst_n) begin
        if (sel_n != 4'hF) begin
            if (prev_sel != 4'hF && sel_n != prev_sel) sw_err++;
            if (!bench_dec && $countones(~sel_n) != 1) two_err++;
            if (prev_sel == 4'hF && seen_act && idle_run < min_idle) min_idle = idle_run;
            seen_act = 1;
            idle_run = 0;
        end else begin
            if (prev_sel != 4'hF) rel_cnt++;
            idle_run++;
        end
        if (spck) hi_run++;
        else begin
            if (prev_sck) last_hi = hi_run;
            hi_run = 0;
        end
        if (sel_n != 4'hF && !spck) lo_run++;
        else begin
            if (lo_run > max_lo) max_lo = lo_run;
            lo_run = 0;
        end
        prev_sel = sel_n;
        prev_sck = spck;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] dt);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input int dv, input bit lst, input bit dec);
        wr(2'd1, {8'(dv), 6'd0, lst, dec});
    endtask

    task automatic set_cfg(input int idx, input bit kp, input int dl);
        wr(2'd2, {8'(dl), 5'd0, kp, 2'(idx)});
    endtask

    task automatic send(input int code, input logic [7:0] w);
        wr(2'd0, {4'd0, 4'(code), w});
    endtask

    task automatic wait_quiet();
        int qn = 0;
        while (qn < 60) begin
            @(negedge clk);
            if (!spck && hold_empty) qn++;
            else qn = 0;
        end
    endtask

    task automatic wait_empty();
        while (!hold_empty) @(negedge clk);
    endtask

    function automatic logic [3:0] exp_sel(input int idx);
        return ~(4'b0001 << idx);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int r0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sel_n", 32'(sel_n), 32'hF);
        chk("R1 spck", 32'(spck), 0);
        chk("R1 mosi", 32'(mosi), 0);
        chk("R1 hold_empty", 32'(hold_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx_data", 32'(rx_data), 0);

        // single word, select 0
        set_mode(1, 0, 0);
        set_cfg(0, 0, 0);
        slv_tx = 8'h3C;
        r0 = rel_cnt;
        send(0, 8'hA5);
        chk("R2 empty low after write", 32'(hold_empty), 0);
        @(negedge clk);
        chk("R2 empty high after move", 32'(hold_empty), 1);
        wait_quiet();
        chk("R3 mosi word", 32'(mon_rx), 32'hA5);
        chk("R3 rx_data", 32'(rx_data), 32'h3C);
        chk("R3 half period", 32'(last_hi), 2);
        chk("R5 released once", 32'(rel_cnt - r0), 1);
        chk("R5 sel idle", 32'(sel_n), 32'hF);

        // back-to-back on select 3 with gap 3
        set_cfg(3, 0, 3);
        slv_tx = 8'h96;
        r0 = rel_cnt;
        max_lo = 0;
        send(3, 8'h11);
        wait_empty();
        send(3, 8'hE7);
        wait_quiet();
        chk("R4 no release between", 32'(rel_cnt - r0), 1);
        chk("R9 gap low time", 32'(max_lo), 3 + 1 + 2);
        chk("R4 second word", 32'(mon_rx), 32'hE7);
        chk("R3 rx second", 32'(rx_data), 32'h96);

        // keep-asserted select 1
        set_cfg(1, 1, 0);
        set_cfg(2, 0, 0);
        r0 = rel_cnt;
        send(1, 8'h5A);
        wait_quiet();
        repeat (100) @(negedge clk);
        chk("R6 held", 32'(sel_n), 32'(exp_sel(1)));
        send(1, 8'hC3);
        wait_quiet();
        chk("R6 still held", 32'(sel_n), 32'(exp_sel(1)));
        chk("R6 no release", 32'(rel_cnt - r0), 0);
        set_mode(1, 1, 0);
        send(1, 8'h0F);
        wait_quiet();
        chk("R7 final release", 32'(sel_n), 32'hF);
        chk("R7 release count", 32'(rel_cnt - r0), 1);
        send(1, 8'hF0);
        wait_quiet();
        chk("R7 flag self-cleared", 32'(sel_n), 32'(exp_sel(1)));

        // switch from held select 1 to select 2
        r0 = rel_cnt;
        min_idle = 1000;
        send(2, 8'h69);
        wait_quiet();
        chk("R8 no direct switch", 32'(sw_err), 0);
        chk("R8 one line low", 32'(two_err), 0);
        chk("R8 idle gap", 32'(min_idle >= 2), 1);
        chk("R8 both released", 32'(rel_cnt - r0), 2);
        chk("R8 word to new select", 32'(mon_rx), 32'h69);

        // decoded mode, code 9 uses config of select 1 (kept)
        bench_dec = 1;
        set_mode(1, 0, 1);
        r0 = rel_cnt;
        send(9, 8'h42);
        wait_quiet();
        chk("R10 decoded code", 32'(sel_n), 32'h9);
        set_mode(1, 1, 1);
        send(9, 8'h24);
        wait_quiet();
        chk("R10 decoded idle", 32'(sel_n), 32'hF);
        chk("R10 release count", 32'(rel_cnt - r0), 1);
        set_mode(1, 0, 0);
        bench_dec = 0;
        repeat (2) @(negedge clk);

        // constrained random
        for (int c = 0; c < 4; c++) set_cfg(c, 0, 0);
        for (int i = 0; i < 24; i++) begin
            int dv, dl, sl;
            logic [7:0] w1, w2;
            dv = $urandom % 4;
            dl = $urandom % 5;
            sl = $urandom % 4;
            w1 = 8'($urandom);
            w2 = 8'($urandom);
            set_mode(dv, 0, 0);
            set_cfg(sl, 0, dl);
            slv_tx = 8'($urandom);
            r0 = rel_cnt;
            max_lo = 0;
            send(sl, w1);
            if (i % 2 == 1) begin
                wait_empty();
                send(sl, w2);
            end
            wait_quiet();
            chk("R3 random rx", 32'(rx_data), 32'(slv_tx));
            chk("R3 random half", 32'(last_hi), 32'(dv + 1));
            chk("R5 random release", 32'(rel_cnt - r0), 1);
            if (i % 2 == 1) begin
                chk("R4 random pair word", 32'(mon_rx), 32'(w2));
                chk("R9 random gap", 32'(max_lo), 32'(dl + dv + 2));
            end else begin
                chk("R3 random word", 32'(mon_rx), 32'(w1));
            end
        end
        chk("R8 final switch errors", 32'(sw_err + two_err), 0);

        summary();
        $finish;
    end
endmodule